// File: doc/BRIEF.md
# Banked DRAM Command Sequencer

This block sits between a memory client and a banked DRAM device. The client hands it read and write requests, each with a bank, row and column address. The block turns them into a legal stream of device commands: activate, precharge, read, write and refresh. It also remembers which row is open in every bank. A request that finds its row already open is served with a single column command. A request that finds a different row open in that bank first closes that row. A request to a closed bank first opens its row.

Pending requests sit in a small ordered queue. Each bank keeps its own open-to-column and close-to-open timers, so work for different banks overlaps. One bank can be opening a row while another bank is being read. Only one command leaves the block per clock, and the oldest request that can legally move forward goes first. A periodic refresh timer stops intake, closes every open bank, issues one refresh and then waits out the refresh time before normal traffic resumes.

Top module: `dram_cmd_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, the command output is NOP (code 0) with bank, row and column zero, and `req_ready_o` is high.
- R2: A request whose row is already open in its bank is served by a column command, RD (code 3) for a read or WR (code 4) for a write, with no ACT before it. That command carries the request's bank, row and column.
- R3: A request to a closed bank produces ACT (code 1) carrying its bank and row. No column command reaches that bank until at least T_RCD cycles after the ACT, and ACT never goes to a bank that is already open.
- R4: A request to a bank that has a different row open produces PRE (code 2) to that bank. No ACT reaches that bank until at least T_RP cycles after the PRE, and PRE only goes to an open bank.
- R5: Any two column commands, to any banks, are at least T_CCD cycles apart.
- R6: At most one command is issued per cycle. Among the queued requests that are not stuck behind an older request to the same bank, the oldest one whose next command is legal wins. Requests to one bank are served in arrival order.
- R7: A younger request to another bank may issue its ACT or column command while an older request waits on its own bank's timer.
- R8: Every T_REFI cycles a refresh becomes due. From then until T_RFC cycles after the REF (code 5) command, `req_ready_o` is low.
- R9: While a refresh is due, the block precharges the open banks one per cycle, lowest bank number first. It issues one REF only once every bank is closed and its T_RP has elapsed. After the refresh every bank is closed, so the next access needs an ACT.
- R10: No command other than NOP is issued during the T_RFC cycles after a REF.
- R11: `req_ready_o` is low while QUEUE_DEPTH requests are pending.
- R12: NOP and REF carry bank, row and column zero. PRE carries row and column zero. ACT carries column zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted at this edge when valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bank_i | input | BANK_W (4) | Target bank |
| req_row_i | input | ROW_W (14) | Target row |
| req_col_i | input | COL_W (10) | Target column |
| cmd_o | output | 3 | Command code: NOP 0, ACT 1, PRE 2, RD 3, WR 4, REF 5 |
| cmd_bank_o | output | BANK_W (4) | Command bank |
| cmd_row_o | output | ROW_W (14) | Command row |
| cmd_col_o | output | COL_W (10) | Command column |

## Verification
The hardest case to reach is a refresh that falls due while the queue holds requests to several banks, some open, some mid-activation and some waiting on a precharge timer. In that case the closing order, the T_RP wait before REF and the reopening afterwards all interact. The bench keeps intake heavy over many refresh intervals, with a narrow row range across all sixteen banks, so the refresh deadline keeps landing on mixed bank states. Directed phases beforehand cover same-bank ordering, a full queue and cross-bank overlap in isolation.

// File: rtl/dcs_pkg.sv
// Package dcs_pkg
// Shared command encoding for the banked DRAM command sequencer.
// Assumes a 3-bit command field on the device side.
package dcs_pkg;
    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_PRE = 3'd2,
        CMD_RD  = 3'd3,
        CMD_WR  = 3'd4,
        CMD_REF = 3'd5
    } dcs_cmd_e;
endpackage

// File: rtl/dcs_req_queue.sv
// Module dcs_req_queue
// Ordered request store. Index 0 always holds the oldest entry, and valid
// entries are contiguous from index 0. Any single entry may be removed;
// younger entries then slide down one place. A push lands just above the
// last valid entry left after the removal.
// Assumes push is only asserted when full_o is low.
module dcs_req_queue #(
    parameter int DEPTH   = 4,
    parameter int ENTRY_W = 29,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    push_i,
    input  logic [ENTRY_W-1:0]      push_data_i,
    input  logic                    pop_i,
    input  logic [IDX_W-1:0]        pop_idx_i,
    output logic [DEPTH-1:0]        vld_o,
    output logic [ENTRY_W-1:0]      data_o [DEPTH],
    output logic                    full_o
);
    logic [DEPTH-1:0]   vld_q, vld_n;
    logic [ENTRY_W-1:0] data_q [DEPTH];
    logic [ENTRY_W-1:0] data_n [DEPTH];

    // Next queue contents: remove the popped entry, then append the push.
    always_comb begin
        logic placed;
        vld_n  = vld_q;
        data_n = data_q;
        placed = 1'b0;
        if (pop_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (i >= int'(pop_idx_i)) begin
                    if (i < DEPTH - 1) begin
                        vld_n[i]  = vld_q[i+1];
                        data_n[i] = data_q[i+1];
                    end else begin
                        vld_n[i] = 1'b0;
                    end
                end
            end
        end
        if (push_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!placed && !vld_n[i]) begin
                    vld_n[i]  = 1'b1;
                    data_n[i] = push_data_i;
                    placed    = 1'b1;
                end
            end
        end
    end

    // Register the queue state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < DEPTH; i++) data_q[i] <= '0;
        end else begin
            vld_q  <= vld_n;
            data_q <= data_n;
        end
    end

    assign vld_o  = vld_q;
    assign data_o = data_q;
    assign full_o = &vld_q;
endmodule

// File: rtl/dcs_bank_ctx.sv
// Module dcs_bank_ctx
// State of one bank: open flag, open row, and two down-counters. One counts
// the activate-to-column wait and the other the precharge-to-activate wait.
// A counter loaded with T-1 at the issuing edge lets the next command go out
// exactly T cycles after the first.
// Assumes act_i and pre_i are never high together. T_RCD and T_RP are >= 1.
module dcs_bank_ctx #(
    parameter int ROW_W = 14,
    parameter int T_RCD = 12,
    parameter int T_RP  = 24,
    localparam int RCD_W = $clog2(T_RCD + 1),
    localparam int RP_W  = $clog2(T_RP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             pre_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o,
    output logic             col_ok_o,
    output logic             act_ok_o
);
    logic             open_q;
    logic [ROW_W-1:0] row_q;
    logic [RCD_W-1:0] rcd_q;
    logic [RP_W-1:0]  rp_q;

    // Open flag and latched row follow ACT and PRE.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            row_q  <= '0;
        end else if (act_i) begin
            open_q <= 1'b1;
            row_q  <= row_i;
        end else if (pre_i) begin
            open_q <= 1'b0;
        end
    end

    // Activate-to-column timer.
    always_ff @(posedge clk) begin
        if (!rst_n)              rcd_q <= '0;
        else if (act_i)          rcd_q <= RCD_W'(T_RCD - 1);
        else if (rcd_q != '0)    rcd_q <= rcd_q - 1'b1;
    end

    // Precharge-to-activate timer.
    always_ff @(posedge clk) begin
        if (!rst_n)              rp_q <= '0;
        else if (pre_i)          rp_q <= RP_W'(T_RP - 1);
        else if (rp_q != '0)     rp_q <= rp_q - 1'b1;
    end

    assign open_o   = open_q;
    assign row_o    = row_q;
    assign col_ok_o = open_q && (rcd_q == '0);
    assign act_ok_o = !open_q && (rp_q == '0);
endmodule

// File: rtl/dcs_refresh_timer.sv
// Module dcs_refresh_timer
// Free-running refresh interval counter. It raises pend_o every T_REFI
// cycles, and pend_o holds until a REF is issued. After a REF, rfc_busy_o
// stays high until the next command may go out T_RFC cycles later.
// Assumes T_REFI >= 1 and T_RFC >= 1.
module dcs_refresh_timer #(
    parameter int T_REFI = 1500,
    parameter int T_RFC  = 30,
    localparam int REFI_W = $clog2(T_REFI + 1),
    localparam int RFC_W  = $clog2(T_RFC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_issue_i,
    output logic pend_o,
    output logic rfc_busy_o
);
    logic [REFI_W-1:0] refi_q;
    logic [RFC_W-1:0]  rfc_q;
    logic              pend_q;

    // Interval counter and due flag. A new deadline wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            refi_q <= REFI_W'(T_REFI - 1);
            pend_q <= 1'b0;
        end else begin
            if (refi_q == '0) refi_q <= REFI_W'(T_REFI - 1);
            else              refi_q <= refi_q - 1'b1;
            if (refi_q == '0)     pend_q <= 1'b1;
            else if (ref_issue_i) pend_q <= 1'b0;
        end
    end

    // Refresh recovery window.
    always_ff @(posedge clk) begin
        if (!rst_n)            rfc_q <= '0;
        else if (ref_issue_i)  rfc_q <= RFC_W'(T_RFC - 1);
        else if (rfc_q != '0)  rfc_q <= rfc_q - 1'b1;
    end

    assign pend_o     = pend_q;
    assign rfc_busy_o = (rfc_q != '0);
endmodule

// File: rtl/dram_cmd_seq.sv
// Module dram_cmd_seq
// Top of the banked DRAM command sequencer. Requests enter an ordered queue.
// Each cycle one command is chosen: during a refresh, closing or refresh
// work; otherwise the oldest queued request whose next step (column, PRE or
// ACT) is legal, skipping entries that sit behind an older request to the
// same bank. The chosen command is registered onto the command outputs.
// Assumes NUM_BANKS is a power of two and all timing parameters are >= 1.
module dram_cmd_seq
    import dcs_pkg::*;
#(
    parameter int NUM_BANKS   = 16,
    parameter int ROW_W       = 14,
    parameter int COL_W       = 10,
    parameter int QUEUE_DEPTH = 4,
    parameter int T_RCD       = 12,
    parameter int T_RP        = 24,
    parameter int T_CCD       = 3,
    parameter int T_REFI      = 1500,
    parameter int T_RFC       = 30,
    localparam int BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic              req_write_i,
    input  logic [BANK_W-1:0] req_bank_i,
    input  logic [ROW_W-1:0]  req_row_i,
    input  logic [COL_W-1:0]  req_col_i,
    output logic [2:0]        cmd_o,
    output logic [BANK_W-1:0] cmd_bank_o,
    output logic [ROW_W-1:0]  cmd_row_o,
    output logic [COL_W-1:0]  cmd_col_o
);
    localparam int ENTRY_W = 1 + BANK_W + ROW_W + COL_W;
    localparam int IDX_W   = (QUEUE_DEPTH > 1) ? $clog2(QUEUE_DEPTH) : 1;
    localparam int CCD_W   = $clog2(T_CCD + 1);
    localparam int BANK_LO = COL_W + ROW_W;

    // Queue signals
    logic [QUEUE_DEPTH-1:0] q_vld;
    logic [ENTRY_W-1:0]     q_data [QUEUE_DEPTH];
    logic                   q_full;
    logic                   q_push;
    logic                   q_pop;
    logic [IDX_W-1:0]       q_pop_idx;

    // Bank state
    logic [NUM_BANKS-1:0] bank_open, bank_col_ok, bank_act_ok;
    logic [NUM_BANKS-1:0] bank_act_sel, bank_pre_sel;
    logic [ROW_W-1:0]     bank_row [NUM_BANKS];

    // Refresh and column spacing
    logic             ref_pend, rfc_busy, ref_issue, col_issue;
    logic [CCD_W-1:0] ccd_q;

    // Chosen command for this cycle
    dcs_cmd_e          nxt_cmd;
    logic [BANK_W-1:0] nxt_bank;
    logic [ROW_W-1:0]  nxt_row;
    logic [COL_W-1:0]  nxt_col;

    assign req_ready_o = !q_full && !ref_pend && !rfc_busy;
    assign q_push      = req_valid_i && req_ready_o;

    dcs_req_queue #(
        .DEPTH   (QUEUE_DEPTH),
        .ENTRY_W (ENTRY_W)
    ) u_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (q_push),
        .push_data_i ({req_write_i, req_bank_i, req_row_i, req_col_i}),
        .pop_i       (q_pop),
        .pop_idx_i   (q_pop_idx),
        .vld_o       (q_vld),
        .data_o      (q_data),
        .full_o      (q_full)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            assign bank_act_sel[b] = (nxt_cmd == CMD_ACT) && (nxt_bank == BANK_W'(b));
            assign bank_pre_sel[b] = (nxt_cmd == CMD_PRE) && (nxt_bank == BANK_W'(b));
            dcs_bank_ctx #(
                .ROW_W (ROW_W),
                .T_RCD (T_RCD),
                .T_RP  (T_RP)
            ) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .act_i    (bank_act_sel[b]),
                .pre_i    (bank_pre_sel[b]),
                .row_i    (nxt_row),
                .open_o   (bank_open[b]),
                .row_o    (bank_row[b]),
                .col_ok_o (bank_col_ok[b]),
                .act_ok_o (bank_act_ok[b])
            );
        end
    endgenerate

    dcs_refresh_timer #(
        .T_REFI (T_REFI),
        .T_RFC  (T_RFC)
    ) u_refresh (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_issue_i (ref_issue),
        .pend_o      (ref_pend),
        .rfc_busy_o  (rfc_busy)
    );

    assign ref_issue = (nxt_cmd == CMD_REF);
    assign col_issue = (nxt_cmd == CMD_RD) || (nxt_cmd == CMD_WR);

    // Column-to-column spacing counter shared by all banks.
    always_ff @(posedge clk) begin
        if (!rst_n)            ccd_q <= '0;
        else if (col_issue)    ccd_q <= CCD_W'(T_CCD - 1);
        else if (ccd_q != '0)  ccd_q <= ccd_q - 1'b1;
    end

    // Arbiter: choose the single command for this cycle.
    always_comb begin
        logic [NUM_BANKS-1:0] seen;
        logic                 found;
        logic                 e_wr;
        logic [BANK_W-1:0]    e_bank;
        logic [ROW_W-1:0]     e_row;
        logic [COL_W-1:0]     e_col;
        nxt_cmd   = CMD_NOP;
        nxt_bank  = '0;
        nxt_row   = '0;
        nxt_col   = '0;
        q_pop     = 1'b0;
        q_pop_idx = '0;
        seen      = '0;
        found     = 1'b0;
        e_wr      = 1'b0;
        e_bank    = '0;
        e_row     = '0;
        e_col     = '0;
        if (rfc_busy) begin
            nxt_cmd = CMD_NOP;
        end else if (ref_pend) begin
            if (|bank_open) begin
                for (int b = NUM_BANKS - 1; b >= 0; b--) begin
                    if (bank_open[b]) nxt_bank = BANK_W'(b);
                end
                nxt_cmd = CMD_PRE;
            end else if (&bank_act_ok) begin
                nxt_cmd = CMD_REF;
            end
        end else begin
            for (int i = 0; i < QUEUE_DEPTH; i++) begin
                e_wr   = q_data[i][ENTRY_W-1];
                e_bank = q_data[i][BANK_LO +: BANK_W];
                e_row  = q_data[i][COL_W +: ROW_W];
                e_col  = q_data[i][COL_W-1:0];
                if (q_vld[i] && !found && !seen[e_bank]) begin
                    if (bank_open[e_bank] && (bank_row[e_bank] == e_row)) begin
                        if (bank_col_ok[e_bank] && (ccd_q == '0)) begin
                            found     = 1'b1;
                            nxt_cmd   = e_wr ? CMD_WR : CMD_RD;
                            nxt_bank  = e_bank;
                            nxt_row   = e_row;
                            nxt_col   = e_col;
                            q_pop     = 1'b1;
                            q_pop_idx = IDX_W'(i);
                        end
                    end else if (bank_open[e_bank]) begin
                        found    = 1'b1;
                        nxt_cmd  = CMD_PRE;
                        nxt_bank = e_bank;
                    end else if (bank_act_ok[e_bank]) begin
                        found    = 1'b1;
                        nxt_cmd  = CMD_ACT;
                        nxt_bank = e_bank;
                        nxt_row  = e_row;
                    end
                end
                if (q_vld[i]) seen[e_bank] = 1'b1;
            end
        end
    end

    // Register the chosen command onto the device-side outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_o      <= CMD_NOP;
            cmd_bank_o <= '0;
            cmd_row_o  <= '0;
            cmd_col_o  <= '0;
        end else begin
            cmd_o      <= nxt_cmd;
            cmd_bank_o <= nxt_bank;
            cmd_row_o  <= nxt_row;
            cmd_col_o  <= nxt_col;
        end
    end
endmodule

// File: rtl/dcs_checker.sv
// Module dcs_checker
// Protocol checker for dram_cmd_seq. It rebuilds the bank state purely from
// the command outputs and checks every command against it: bank open state
// and the per-bank and shared timing windows. Bound to the top below.
module dcs_checker
    import dcs_pkg::*;
#(
    parameter int NUM_BANKS = 16,
    parameter int ROW_W     = 14,
    parameter int COL_W     = 10,
    parameter int T_RCD     = 12,
    parameter int T_RP      = 24,
    parameter int T_CCD     = 3,
    parameter int T_RFC     = 30,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int LIM      = (T_RCD > T_RP) ? T_RCD : T_RP,
    localparam int LIM_W    = $clog2(LIM + 1),
    localparam int CCD_W    = $clog2(T_CCD + 1),
    localparam int RFC_W    = $clog2(T_RFC + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready_o,
    input logic [2:0]        cmd_o,
    input logic [BANK_W-1:0] cmd_bank_o,
    input logic [ROW_W-1:0]  cmd_row_o,
    input logic [COL_W-1:0]  cmd_col_o
);
    logic [NUM_BANKS-1:0] chk_open;
    logic [ROW_W-1:0]     chk_row   [NUM_BANKS];
    logic [LIM_W-1:0]     since_act [NUM_BANKS];
    logic [LIM_W-1:0]     since_pre [NUM_BANKS];
    logic [CCD_W-1:0]     since_col;
    logic [RFC_W-1:0]     since_ref;
    logic                 is_col;

    assign is_col = (cmd_o == CMD_RD) || (cmd_o == CMD_WR);

    // Per-bank shadow state, rebuilt from observed commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_open <= '0;
            for (int b = 0; b < NUM_BANKS; b++) begin
                chk_row[b]   <= '0;
                since_act[b] <= LIM_W'(LIM);
                since_pre[b] <= LIM_W'(LIM);
            end
        end else begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (cmd_o == CMD_ACT && cmd_bank_o == BANK_W'(b)) begin
                    chk_open[b]  <= 1'b1;
                    chk_row[b]   <= cmd_row_o;
                    since_act[b] <= LIM_W'(1);
                end else if (since_act[b] != LIM_W'(LIM)) begin
                    since_act[b] <= since_act[b] + 1'b1;
                end
                if (cmd_o == CMD_PRE && cmd_bank_o == BANK_W'(b)) begin
                    chk_open[b]  <= 1'b0;
                    since_pre[b] <= LIM_W'(1);
                end else if (since_pre[b] != LIM_W'(LIM)) begin
                    since_pre[b] <= since_pre[b] + 1'b1;
                end
            end
        end
    end

    // Shared column and refresh spacing counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_col <= CCD_W'(T_CCD);
            since_ref <= RFC_W'(T_RFC);
        end else begin
            if (is_col)                          since_col <= CCD_W'(1);
            else if (since_col != CCD_W'(T_CCD)) since_col <= since_col + 1'b1;
            if (cmd_o == CMD_REF)                since_ref <= RFC_W'(1);
            else if (since_ref != RFC_W'(T_RFC)) since_ref <= since_ref + 1'b1;
        end
    end

    assert_col_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> (chk_open[cmd_bank_o] && chk_row[cmd_bank_o] == cmd_row_o));

    assert_rcd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> (int'(since_act[cmd_bank_o]) >= T_RCD));

    assert_act_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_ACT) |-> !chk_open[cmd_bank_o]);

    assert_rp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_ACT) |-> (int'(since_pre[cmd_bank_o]) >= T_RP));

    assert_pre_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_PRE) |-> chk_open[cmd_bank_o]);

    assert_ccd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> (int'(since_col) >= T_CCD));

    assert_ready_refresh_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_REF) |-> $past(!req_ready_o));

    assert_ref_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_REF) |-> (chk_open == '0));

    assert_rfc_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o != CMD_NOP) |-> (int'(since_ref) >= T_RFC));

    assert_fields_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_NOP || cmd_o == CMD_REF) |->
            (cmd_bank_o == '0 && cmd_row_o == '0 && cmd_col_o == '0));
endmodule

bind dram_cmd_seq dcs_checker #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W),
    .COL_W     (COL_W),
    .T_RCD     (T_RCD),
    .T_RP      (T_RP),
    .T_CCD     (T_CCD),
    .T_RFC     (T_RFC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready_o (req_ready_o),
    .cmd_o       (cmd_o),
    .cmd_bank_o  (cmd_bank_o),
    .cmd_row_o   (cmd_row_o),
    .cmd_col_o   (cmd_col_o)
);

// File: tb/dram_cmd_seq_tb.sv
// Testbench for dram_cmd_seq. A behavioural reference model (request queue,
// per-bank cycle stamps) predicts the command and ready value of every cycle.
// An independent legality monitor also checks the observed command stream.
module dram_cmd_seq_tb;
    localparam int NB     = 16;
    localparam int BW     = 4;
    localparam int RW     = 14;
    localparam int CW     = 10;
    localparam int DEPTH  = 4;
    localparam int T_RCD  = 12;
    localparam int T_RP   = 24;
    localparam int T_CCD  = 3;
    localparam int T_REFI = 700;
    localparam int T_RFC  = 30;

    typedef struct packed {
        logic          wr;
        logic [BW-1:0] bank;
        logic [RW-1:0] row;
        logic [CW-1:0] col;
    } req_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid_i = 1'b0;
    logic          req_ready_o;
    logic          req_write_i = 1'b0;
    logic [BW-1:0] req_bank_i = '0;
    logic [RW-1:0] req_row_i = '0;
    logic [CW-1:0] req_col_i = '0;
    logic [2:0]    cmd_o;
    logic [BW-1:0] cmd_bank_o;
    logic [RW-1:0] cmd_row_o;
    logic [CW-1:0] cmd_col_o;

    always #5 clk = ~clk;

    dram_cmd_seq #(
        .NUM_BANKS(NB), .ROW_W(RW), .COL_W(CW), .QUEUE_DEPTH(DEPTH),
        .T_RCD(T_RCD), .T_RP(T_RP), .T_CCD(T_CCD), .T_REFI(T_REFI), .T_RFC(T_RFC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
        .req_write_i(req_write_i), .req_bank_i(req_bank_i), .req_row_i(req_row_i),
        .req_col_i(req_col_i), .cmd_o(cmd_o), .cmd_bank_o(cmd_bank_o),
        .cmd_row_o(cmd_row_o), .cmd_col_o(cmd_col_o)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Reference model state
    req_t mq[$];
    bit   m_open [NB];
    int   m_row [NB];
    int   m_act_at [NB];
    int   m_pre_at [NB];
    int   m_col_at = -1000;
    int   m_ref_at = -1000;
    bit   m_pend = 1'b0;
    int   m_e = 0;
    int   x_cmd = 0, x_bank = 0, x_row = 0, x_col = 0;
    bit   x_ref_phase = 1'b0;

    // Observation monitor state
    bit   o_open [NB];
    int   o_row [NB];
    int   o_act_at [NB];
    int   o_pre_at [NB];
    int   o_col_at = -1000;
    int   o_refs = 0;
    bit   saw_full = 1'b0;
    int   log_bank[$];
    int   log_row[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, m_e);
        end
    endtask

    function automatic bit m_busy(input int e);
        return m_pend || (e < m_ref_at + T_RFC);
    endfunction

    function automatic bit m_ready(input int e);
        return (mq.size() < DEPTH) && !m_busy(e);
    endfunction

    // Advance the reference model across one clock edge.
    task automatic model_step(input bit v, input req_t r);
        int  e;
        bit  rdy;
        bit  found;
        int  pidx;
        bit  seen [NB];
        e = m_e + 1;
        rdy = m_ready(e);
        x_cmd = 0; x_bank = 0; x_row = 0; x_col = 0;
        x_ref_phase = m_pend;
        found = 1'b0;
        pidx = -1;
        foreach (seen[b]) seen[b] = 1'b0;
        if (e < m_ref_at + T_RFC) begin
            x_cmd = 0;
        end else if (m_pend) begin
            for (int b = 0; b < NB; b++) begin
                if (!found && m_open[b]) begin
                    found = 1'b1; x_cmd = 2; x_bank = b;
                end
            end
            if (!found) begin
                bit all_rp;
                all_rp = 1'b1;
                for (int b = 0; b < NB; b++) if (e - m_pre_at[b] < T_RP) all_rp = 1'b0;
                if (all_rp) x_cmd = 5;
            end
        end else begin
            for (int i = 0; i < mq.size(); i++) begin
                int b;
                b = int'(mq[i].bank);
                if (!found && !seen[b]) begin
                    if (m_open[b] && m_row[b] == int'(mq[i].row)) begin
                        if (e - m_act_at[b] >= T_RCD && e - m_col_at >= T_CCD) begin
                            found = 1'b1; x_cmd = mq[i].wr ? 4 : 3;
                            x_bank = b; x_row = int'(mq[i].row); x_col = int'(mq[i].col);
                            pidx = i;
                        end
                    end else if (m_open[b]) begin
                        found = 1'b1; x_cmd = 2; x_bank = b;
                    end else if (e - m_pre_at[b] >= T_RP) begin
                        found = 1'b1; x_cmd = 1; x_bank = b; x_row = int'(mq[i].row);
                    end
                end
                seen[b] = 1'b1;
            end
        end
        case (x_cmd)
            1: begin m_open[x_bank] = 1'b1; m_row[x_bank] = x_row; m_act_at[x_bank] = e; end
            2: begin m_open[x_bank] = 1'b0; m_pre_at[x_bank] = e; end
            3, 4: begin m_col_at = e; mq.delete(pidx); end
            5: begin m_ref_at = e; m_pend = 1'b0; end
            default: ;
        endcase
        if (e % T_REFI == 0) m_pend = 1'b1;
        if (v && rdy) mq.push_back(r);
        m_e = e;
    endtask

    // Compare outputs with the model and run the legality monitor.
    task automatic observe();
        int c, b;
        string tag;
        c = int'(cmd_o);
        b = int'(cmd_bank_o);
        case (x_cmd)
            1: tag = "R3";
            2: tag = x_ref_phase ? "R9" : "R4";
            3, 4: tag = "R2";
            5: tag = "R8";
            default: tag = (m_e < m_ref_at + T_RFC) ? "R10" : "R6";
        endcase
        check(c == x_cmd, tag, c, x_cmd);
        if (x_cmd == 0 || x_cmd == 2 || x_cmd == 5) tag = "R12";
        check(b == x_bank && int'(cmd_row_o) == x_row && int'(cmd_col_o) == x_col,
              tag, b * 100000 + int'(cmd_row_o), x_bank * 100000 + x_row);
        if (c == 3 || c == 4) begin
            check(o_open[b] && o_row[b] == int'(cmd_row_o), "R2", int'(o_open[b]), 1);
            check(m_e - o_act_at[b] >= T_RCD, "R3", m_e - o_act_at[b], T_RCD);
            check(m_e - o_col_at >= T_CCD, "R5", m_e - o_col_at, T_CCD);
            o_col_at = m_e;
            log_bank.push_back(b);
            log_row.push_back(int'(cmd_row_o));
        end else if (c == 1) begin
            check(m_e - o_pre_at[b] >= T_RP, "R4", m_e - o_pre_at[b], T_RP);
            o_open[b] = 1'b1; o_row[b] = int'(cmd_row_o); o_act_at[b] = m_e;
        end else if (c == 2) begin
            o_open[b] = 1'b0; o_pre_at[b] = m_e;
        end else if (c == 5) begin
            int n_open;
            n_open = 0;
            foreach (o_open[k]) if (o_open[k]) n_open++;
            check(n_open == 0, "R9", n_open, 0);
            o_refs++;
        end
    endtask

    // One clock: check at the falling edge, drive inputs, step the model.
    task automatic cycle(input bit v, input req_t r, output bit accepted);
        bit exp_rdy;
        @(negedge clk);
        observe();
        exp_rdy = m_ready(m_e + 1);
        check(req_ready_o == exp_rdy, (mq.size() >= DEPTH) ? "R11" : "R8",
              int'(req_ready_o), int'(exp_rdy));
        if (!req_ready_o && !m_busy(m_e + 1)) saw_full = 1'b1;
        req_valid_i = v;
        req_write_i = r.wr;
        req_bank_i  = r.bank;
        req_row_i   = r.row;
        req_col_i   = r.col;
        accepted = v && exp_rdy;
        model_step(v, r);
    endtask

    task automatic send(input bit wr, input int bank, input int row, input int col);
        req_t r;
        bit   acc;
        r.wr = wr; r.bank = BW'(bank); r.row = RW'(row); r.col = CW'(col);
        acc = 1'b0;
        while (!acc) cycle(1'b1, r, acc);
    endtask

    task automatic idle(input int n);
        bit acc;
        for (int i = 0; i < n; i++) cycle(1'b0, '0, acc);
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(1_500_000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            report();
        end
    end

    initial begin
        int pos [3];
        int k;
        foreach (m_open[b]) begin
            m_open[b] = 1'b0; m_row[b] = 0; m_act_at[b] = -1000; m_pre_at[b] = -1000;
            o_open[b] = 1'b0; o_row[b] = 0; o_act_at[b] = -1000; o_pre_at[b] = -1000;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(cmd_o == 3'd0, "R1", int'(cmd_o), 0);
        check(cmd_bank_o == '0 && cmd_row_o == '0 && cmd_col_o == '0, "R1",
              int'(cmd_row_o), 0);
        check(req_ready_o == 1'b1, "R1", int'(req_ready_o), 1);
        rst_n = 1'b1;
        model_step(1'b0, '0);

        // R2, R5: burst of row hits to one bank after a single activation
        for (int i = 0; i < 4; i++) send(i[0], 1, 10, i);
        idle(40);

        // R7: three banks opened before the first column command goes out
        send(1'b0, 6, 4, 8);
        send(1'b0, 7, 7, 32);
        send(1'b0, 8, 10, 1);
        idle(40);
        check(o_act_at[8] < o_col_at - 2 * T_CCD, "R7", o_act_at[8], o_col_at);

        // R4: row miss on an open bank
        send(1'b1, 6, 5, 9);
        idle(60);

        // R6, R11: same-bank ordering with a full queue
        send(1'b0, 9, 1, 0);
        send(1'b0, 9, 2, 0);
        send(1'b0, 9, 1, 1);
        send(1'b0, 10, 3, 0);
        send(1'b0, 11, 3, 0);
        idle(200);
        k = 0;
        for (int i = 0; i < log_bank.size(); i++)
            if (log_bank[i] == 9 && k < 3) begin pos[k] = log_row[i]; k++; end
        check(k == 3 && pos[0] == 1 && pos[1] == 2 && pos[2] == 1, "R6", pos[1], 2);
        check(saw_full, "R11", int'(saw_full), 1);

        // R8, R9: wait past a refresh deadline
        idle(T_REFI);
        check(o_refs >= 1, "R9", o_refs, 1);

        // Heavy mixed traffic across many refresh intervals
        for (int n = 0; n < 3500; n++) begin
            req_t r;
            bit   acc;
            r.wr   = 1'($urandom_range(0, 1));
            r.bank = BW'($urandom_range(0, NB - 1));
            r.row  = RW'($urandom_range(0, 3));
            r.col  = CW'($urandom_range(0, 1023));
            cycle($urandom_range(0, 9) < 7, r, acc);
        end
        idle(300);
        check(o_refs >= 5, "R8", o_refs, 5);
        check(mq.size() == 0, "R6", mq.size(), 0);
        finished = 1'b1;
        report();
    end
endmodule